// File: doc/BRIEF.md
# Serial Converter Frame Sequencer

This block drives one complete conversion cycle on an eight-channel, 16-bit successive-approximation converter. The converter sits on a four-wire serial link: active-low select, a serial clock from the host, host-to-converter data and converter-to-host data. A one-cycle `start` pulse latches a 3-bit channel address and a single-ended/differential flag. The block then pulls select low and clocks out a control byte. While the rest of that byte is sent, the converter acquires its sample. The block then clocks in the 16-bit result and raises `result_valid` for one cycle, together with the channel and mode the result belongs to.

A frame always has 24 serial clocks, in three back-to-back groups of eight. The serial clock is made from the system clock, with each half period lasting `HALF_DIV` system cycles. A result code of N stands for N times the reference voltage divided by 65536.

Top module: `adc_frame_host`

## Requirements
- R1: After reset, `cs_n` is high, `sclk` is low, and `busy` and `result_valid` are low.
- R2: Each frame has exactly 24 rising edges of `sclk`. All of them fall while `cs_n` is low, and `sclk` is never high while `cs_n` is high.
- R3: On the first eight rising edges, `mosi` carries the control byte MSB first: a 1 (start bit), then A2, A1, A0 of the channel, then the mode bit (1 = single-ended, 0 = differential), then `PWR_MODE[2:0]` MSB first. On rising edges 9 to 24, `mosi` is 0.
- R4: `mosi` changes only while `sclk` is low. It is updated on falling edges, or when a frame starts.
- R5: On rising edges 9 to 24, `miso` is sampled and shifted into `result` MSB first. Rising edge 9 gives bit 15 and rising edge 24 gives bit 0.
- R6: `result_valid` is a one-cycle pulse. It is raised in the same cycle that `cs_n` returns high, half a serial period after the 24th falling edge. With it, `result_chan` and `result_single` hold the channel and mode that were latched at the start.
- R7: A `start` pulse while `busy` is high has no effect. The running frame keeps its channel, mode and length, and no further frame follows it.
- R8: `busy` rises in the cycle after `start` is accepted. It stays high up to and including the `result_valid` cycle and is low in the next cycle.
- R9: `cs_n` falls `HALF_DIV` system cycles before the first rising edge of `sclk`. Each `sclk` high and low phase lasts `HALF_DIV` system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a frame |
| chan | input | 3 | Channel address for the requested frame |
| single | input | 1 | 1 = single-ended, 0 = differential |
| cs_n | output | 1 | Converter select, active low |
| sclk | output | 1 | Serial clock to the converter, idle low |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |
| result | output | 16 | Conversion result |
| result_valid | output | 1 | One-cycle strobe when `result` is complete |
| result_chan | output | 3 | Channel tag of the result |
| result_single | output | 1 | Mode tag of the result |
| busy | output | 1 | Frame in progress |

## Verification
The bench sweeps all sixteen channel and mode combinations. It models the converter by capturing the control byte on rising edges and returning a result word bit by bit on falling edges. The words include all-zero and all-one results and patterns that change with the channel, so an off-by-one sampling window would show up as a shifted or truncated result. A start pulse in the middle of a frame checks that a design which restarted, or which took the new channel, would be caught: the tags, the edge count or a trailing extra frame would differ. The bench also measures the select-to-first-edge delay and checks that `busy` drops exactly one cycle after the strobe.

// File: rtl/adc_frame_host.sv
module adc_frame_host #(
  parameter int HALF_DIV = 2,
  parameter logic [2:0] PWR_MODE = 3'b011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  chan,
  input  logic        single,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [15:0] result,
  output logic        result_valid,
  output logic [2:0]  result_chan,
  output logic        result_single,
  output logic        busy
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CMAX = CW'(HALF_DIV - 1);
  localparam logic [5:0] LAST_PH = 6'd48;
  localparam logic [4:0] FIRST_DATA = 5'd8;

  logic          active;
  logic [CW-1:0] cnt;
  logic [5:0]    ph;
  logic [7:0]    ctl;
  logic [15:0]   sreg;
  logic          tick;

  assign tick   = active && (cnt == CMAX);
  assign busy   = active || result_valid;
  assign mosi   = ctl[7];
  assign result = sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active        <= 1'b0;
      cnt           <= '0;
      ph            <= '0;
      ctl           <= '0;
      sreg          <= '0;
      cs_n          <= 1'b1;
      sclk          <= 1'b0;
      result_valid  <= 1'b0;
      result_chan   <= '0;
      result_single <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (!busy && start) begin
        active        <= 1'b1;
        cnt           <= '0;
        ph            <= '0;
        cs_n          <= 1'b0;
        sclk          <= 1'b0;
        ctl           <= {1'b1, chan, single, PWR_MODE};
        result_chan   <= chan;
        result_single <= single;
      end else if (active) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) begin
          ph <= ph + 6'd1;
          if (ph == LAST_PH) begin
            active       <= 1'b0;
            cs_n         <= 1'b1;
            result_valid <= 1'b1;
          end else if (!ph[0]) begin
            sclk <= 1'b1;
            if (ph[5:1] >= FIRST_DATA) sreg <= {sreg[14:0], miso};
          end else begin
            sclk <= 1'b0;
            ctl  <= {ctl[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

module adc_frame_host_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic result_valid,
  input logic busy
);
  assert_sclk_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  assert_mosi_on_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> !sclk);
  assert_valid_with_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> result_valid);
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> busy ##1 !busy);
  assert_idle_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n && !sclk);
endmodule

bind adc_frame_host adc_frame_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
  .result_valid(result_valid), .busy(busy)
);

// File: tb/adc_frame_host_test.sv
`timescale 1ns/1ps
module adc_frame_host_test;
  localparam int HALF = 2;
  localparam logic [2:0] PWR = 3'b011;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, single = 1'b0, miso = 1'b0;
  logic [2:0] chan = '0;
  logic cs_n, sclk, mosi, result_valid, result_single, busy;
  logic [15:0] result;
  logic [2:0] result_chan;

  int checks = 0, fails = 0, cycles = 0;
  int rises = 0, fc = 0, tail_bad = 0;
  logic [7:0] cap = '0;
  logic [15:0] next_word = '0;
  realtime t_cs = 0, t_rise = 0;

  adc_frame_host #(.HALF_DIV(HALF), .PWR_MODE(PWR)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .single(single),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso), .result(result),
    .result_valid(result_valid), .result_chan(result_chan),
    .result_single(result_single), .busy(busy));

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      finish_run();
    end
  end

  always @(negedge cs_n) begin
    rises = 0; fc = 0; tail_bad = 0; cap = '0; miso <= 1'b0; t_cs = $realtime;
  end
  always @(posedge sclk) begin
    if (rises == 0) t_rise = $realtime;
    if (rises < 8) cap = {cap[6:0], mosi};
    else if (mosi) tail_bad++;
    rises++;
  end
  always @(negedge sclk) begin
    fc++;
    miso <= (fc >= 8 && fc <= 23) ? next_word[23-fc] : 1'b0;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [2:0] ch, input logic sg, input logic [15:0] w,
                       input bit poke);
    int n = 0;
    next_word = w;
    @(negedge clk); start = 1'b1; chan = ch; single = sg;
    @(negedge clk); start = 1'b0;
    check("R8 busy after start", busy, 1);
    while (!result_valid && n < 1000) begin
      @(negedge clk); n++;
      if (poke && n == 20) begin start = 1'b1; chan = ~ch; single = ~sg; end
      if (poke && n == 21) start = 1'b0;
    end
    check("R6 valid seen", result_valid, 1);
    check("R5 result", result, w);
    check("R6 chan tag", result_chan, ch);
    check("R6 mode tag", result_single, sg);
    check("R6 cs high with valid", cs_n, 1);
    check("R2 rising edges", rises, 24);
    check("R3 control byte", cap, {1'b1, ch, sg, PWR});
    check("R3 tail zero", tail_bad, 0);
    check("R9 lead time", longint'((t_rise - t_cs) / 20.0), HALF);
    @(negedge clk);
    check("R8 busy low after valid", busy, 0);
    check("R6 valid one cycle", result_valid, 0);
    if (poke) begin
      repeat (10 * HALF) begin
        @(negedge clk);
        check("R7 no extra frame", cs_n, 1);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cs idle", cs_n, 1);
    check("R1 sclk idle", sclk, 0);
    check("R1 busy idle", busy, 0);
    check("R1 valid idle", result_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 2; s++)
        frame(c[2:0], s[0], 16'hA5C3 ^ 16'(c * 16'h1357) ^ (s[0] ? 16'hFFFF : 16'h0), 1'b0);
    frame(3'd0, 1'b1, 16'h0000, 1'b0);
    frame(3'd7, 1'b0, 16'hFFFF, 1'b0);
    frame(3'd5, 1'b1, 16'h8001, 1'b1);
    frame(3'd2, 1'b0, 16'h7FFE, 1'b1);
    finish_run();
  end
endmodule